// File: doc/BRIEF.md
# Comparison Clock Divider and Phase-Frequency Detector

This block turns an oversampled reference clock into a comparison clock by dividing it by one of 29 ratios. A 5-bit ratio code selects the ratio. The block then compares the comparison clock in phase and frequency against the feedback divider output of a synthesizer loop. It produces digital pump-up and pump-down pulses for an analog charge pump that sits outside the block. It also keeps a lock flag.

A 4-bit test field can force the pump outputs and the lock flag. It can also route either the comparison clock or half the feedback clock onto a general-purpose output port instead of that port's normal data.

Both clock inputs are levels that are already synchronous to the system clock `clk`. Rising edges are detected with one register per input, so both paths have the same latency. The phase-frequency detector is a four-state machine:

- `PD_IDLE`
  - to `PD_LEAD` on a comparison edge alone
  - to `PD_LAG` on a feedback edge alone
  - to `PD_CLEAR` when both edges arrive together
- `PD_LEAD`
  - to `PD_CLEAR` on a feedback edge
  - stays in `PD_LEAD` on further comparison edges
- `PD_LAG`
  - to `PD_CLEAR` on a comparison edge
  - stays in `PD_LAG` on further feedback edges
- `PD_CLEAR`
  - back to `PD_IDLE` after a fixed reset delay of 2 cycles, which removes the dead zone

Top module: `refcmp_top`

## Requirements
- R1: With ratio_code[4:3]=00, the comparison clock period is 2^(ratio_code[2:0]+1) reference periods (2 up to 256).
- R2: With ratio_code[4:3] = 01, 10 or 11 and ratio_code[2:0] from 001 to 111, the divide ratio is M·2^(ratio_code[2:0]−1). M is 5, 6 or 7 respectively, so the ratios run from 5 to 448.
- R3: A reserved code (ratio_code[4:3] nonzero and ratio_code[2:0]=000) leaves the previously selected ratio in use. After reset the ratio is 2.
- R4: The detector's up output rises only after a comparison edge, and its down output rises only after a feedback edge. When both are high, they are held together for exactly 2 cycles and then both are cleared. When feedback edges are absent, up stays high.
- R5: lock_flag goes to 1 after 64 consecutive comparison periods in which the one-sided pulse (up without down, or down without up) lasts under 2 cycles. It clears as soon as a one-sided pulse reaches 2 cycles.
- R6: With test_en=1, test_sel[1:0] controls the pump and the flag:
  - 01 forces sink: pump_dn=1, pump_up=0, lock_flag=0.
  - 10 forces source: pump_up=1, pump_dn=0, lock_flag=0.
  - 11 turns the pump off: both pump outputs are 0 and lock_flag=1.
- R7: With test_en=0, or with test_sel[1:0]=00, the pump outputs and lock_flag follow the detector and the lock detector. The overrides do not disturb the internal lock state.
- R8: With test_en=1 and test_sel[2]=1, p0_out carries the feedback clock divided by 2 when test_sel[1:0]=00, and the comparison clock otherwise. In every other case p0_out equals p0_drive.
- R9: While rst_n is low, pump_up, pump_dn and lock_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference clock level, synchronous to clk |
| fb_in | input | 1 | Feedback divider output level, synchronous to clk |
| ratio_code | input | 5 | Reference divide ratio select |
| test_en | input | 1 | Test mode enable |
| test_sel | input | 3 | Test mode select; bit 2 routes a clock to p0_out |
| p0_drive | input | 1 | Normal data for the general-purpose port |
| pump_up | output | 1 | Charge pump source request |
| pump_dn | output | 1 | Charge pump sink request |
| lock_flag | output | 1 | Phase-lock indication |
| p0_out | output | 1 | General-purpose port output |

## Verification
On every cycle, the assertions check that each detector output rises only after its own edge, and that the overlap of up and down lasts exactly the reset delay and then releases. They also check that the comparison period never exceeds the largest ratio, that a two-cycle one-sided pulse always leaves the lock flag low, and that the forced test modes hold at the ports.

Only the bench's scenarios can show the following:
- the exact divide ratio for each code, and that reserved codes keep the previous ratio;
- that lock builds up over 64 clean periods and survives a one-cycle phase offset in either direction;
- the direction of the pump pulse for leading and lagging feedback;
- which clock the test port carries.

// File: rtl/refcmp_pkg.sv
package refcmp_pkg;

    localparam int MAX_RATIO = 448;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);

    typedef enum logic [1:0] {
        PD_IDLE,
        PD_LEAD,
        PD_LAG,
        PD_CLEAR
    } pd_state_e;

    typedef enum logic [1:0] {
        TM_NORMAL,
        TM_SINK,
        TM_SOURCE,
        TM_OFF
    } tmode_e;

    function automatic tmode_e decode_tmode(input logic te, input logic [1:0] sel);
        tmode_e m;
        if (!te) begin
            m = TM_NORMAL;
        end else begin
            unique case (sel)
                2'b00: m = TM_NORMAL;
                2'b01: m = TM_SINK;
                2'b10: m = TM_SOURCE;
                2'b11: m = TM_OFF;
            endcase
        end
        return m;
    endfunction

    function automatic logic code_reserved(input logic [4:0] code);
        return (code[4:3] != 2'b00) && (code[2:0] == 3'b000);
    endfunction

    function automatic logic [RATIO_W-1:0] code_ratio(input logic [4:0] code);
        logic [RATIO_W-1:0] base;
        logic [2:0]         shamt;
        unique case (code[4:3])
            2'b00: base = RATIO_W'(2);
            2'b01: base = RATIO_W'(5);
            2'b10: base = RATIO_W'(6);
            2'b11: base = RATIO_W'(7);
        endcase
        shamt = (code[4:3] == 2'b00) ? code[2:0] : (code[2:0] - 3'd1);
        return base << shamt;
    endfunction

endpackage

// File: rtl/refcmp_refdiv.sv
module refcmp_refdiv
    import refcmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_edge,
    input  logic [4:0] ratio_code,
    output logic       comp_tick,
    output logic       comp_lvl
);

    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] cnt_q;
    logic               wrap;

    // a reserved code keeps whatever ratio was last accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= RATIO_W'(2);
        end else if (!code_reserved(ratio_code)) begin
            ratio_q <= code_ratio(ratio_code);
        end
    end

    // >= so that a ratio reduced mid-count still wraps at once
    assign wrap = (cnt_q >= ratio_q - RATIO_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            comp_tick <= 1'b0;
        end else begin
            comp_tick <= 1'b0;
            if (ref_edge) begin
                if (wrap) begin
                    cnt_q     <= '0;
                    comp_tick <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + RATIO_W'(1);
                end
            end
        end
    end

    // square-ish comparison clock for the test port
    assign comp_lvl = (cnt_q < (ratio_q >> 1));

endmodule

// File: rtl/refcmp_pfd.sv
module refcmp_pfd
    import refcmp_pkg::*;
#(
    parameter int RST_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comp_tick,
    input  logic fb_tick,
    output logic pd_up,
    output logic pd_dn,
    output logic pd_one_sided,
    output logic pd_settle
);

    localparam int DW = $clog2(RST_DLY + 1);

    pd_state_e      state_q, state_d;
    logic [DW-1:0]  dly_q;
    logic           dly_done;

    assign dly_done = (dly_q == DW'(RST_DLY - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: begin
                if (comp_tick && fb_tick) state_d = PD_CLEAR;
                else if (comp_tick)       state_d = PD_LEAD;
                else if (fb_tick)         state_d = PD_LAG;
            end
            PD_LEAD:  if (fb_tick)   state_d = PD_CLEAR;
            PD_LAG:   if (comp_tick) state_d = PD_CLEAR;
            PD_CLEAR: if (dly_done)  state_d = PD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PD_IDLE;
            dly_q   <= '0;
        end else begin
            state_q <= state_d;
            dly_q   <= (state_q == PD_CLEAR) ? dly_q + DW'(1) : '0;
        end
    end

    always_comb begin
        pd_up        = 1'b0;
        pd_dn        = 1'b0;
        pd_one_sided = 1'b0;
        pd_settle    = 1'b0;
        unique case (state_q)
            PD_IDLE: ;
            PD_LEAD: begin
                pd_up        = 1'b1;
                pd_one_sided = 1'b1;
            end
            PD_LAG: begin
                pd_dn        = 1'b1;
                pd_one_sided = 1'b1;
            end
            PD_CLEAR: begin
                pd_up     = 1'b1;
                pd_dn     = 1'b1;
                pd_settle = dly_done;
            end
        endcase
    end

endmodule

// File: rtl/refcmp_lockdet.sv
module refcmp_lockdet #(
    parameter int LOCK_PERIODS = 64,
    parameter int LOCK_TOL     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic one_sided,
    input  logic settle,
    output logic locked
);

    localparam int EW = $clog2(LOCK_TOL + 1);
    localparam int GW = $clog2(LOCK_PERIODS + 1);

    logic [EW-1:0] err_q;
    logic [GW-1:0] good_q;
    logic          breach;

    // the LOCK_TOL-th one-sided cycle in a period breaks the run at once
    assign breach = one_sided && (err_q >= EW'(LOCK_TOL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= '0;
            good_q <= '0;
        end else begin
            if (settle)
                err_q <= '0;
            else if (one_sided && (err_q < EW'(LOCK_TOL - 1)))
                err_q <= err_q + EW'(1);

            if (breach)
                good_q <= '0;
            else if (settle && (good_q < GW'(LOCK_PERIODS)))
                good_q <= good_q + GW'(1);
        end
    end

    assign locked = (good_q == GW'(LOCK_PERIODS));

endmodule

// File: rtl/refcmp_top.sv
module refcmp_top
    import refcmp_pkg::*;
#(
    parameter int RST_DLY      = 2,
    parameter int LOCK_PERIODS = 64,
    parameter int LOCK_TOL     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic       fb_in,
    input  logic [4:0] ratio_code,
    input  logic       test_en,
    input  logic [2:0] test_sel,
    input  logic       p0_drive,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       lock_flag,
    output logic       p0_out
);

    logic   ref_q, fb_q;
    logic   ref_edge;
    logic   fb_tick;
    logic   fb_half;
    logic   comp_tick, comp_lvl;
    logic   pd_up, pd_dn, pd_one_sided, pd_settle;
    logic   locked;
    tmode_e tmode;

    assign ref_edge = ref_in && !ref_q;

    // feedback edge registered once so it lines up with the divider tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= 1'b0;
            fb_q    <= 1'b0;
            fb_tick <= 1'b0;
            fb_half <= 1'b0;
        end else begin
            ref_q   <= ref_in;
            fb_q    <= fb_in;
            fb_tick <= fb_in && !fb_q;
            if (fb_tick) fb_half <= !fb_half;
        end
    end

    refcmp_refdiv u_refdiv (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_edge   (ref_edge),
        .ratio_code (ratio_code),
        .comp_tick  (comp_tick),
        .comp_lvl   (comp_lvl)
    );

    refcmp_pfd #(.RST_DLY(RST_DLY)) u_pfd (
        .clk          (clk),
        .rst_n        (rst_n),
        .comp_tick    (comp_tick),
        .fb_tick      (fb_tick),
        .pd_up        (pd_up),
        .pd_dn        (pd_dn),
        .pd_one_sided (pd_one_sided),
        .pd_settle    (pd_settle)
    );

    refcmp_lockdet #(.LOCK_PERIODS(LOCK_PERIODS), .LOCK_TOL(LOCK_TOL)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .one_sided (pd_one_sided),
        .settle    (pd_settle),
        .locked    (locked)
    );

    assign tmode = decode_tmode(test_en, test_sel[1:0]);

    always_comb begin
        pump_up   = 1'b0;
        pump_dn   = 1'b0;
        lock_flag = 1'b0;
        unique case (tmode)
            TM_NORMAL: begin
                pump_up   = pd_up;
                pump_dn   = pd_dn;
                lock_flag = locked;
            end
            TM_SINK:   pump_dn   = 1'b1;
            TM_SOURCE: pump_up   = 1'b1;
            TM_OFF:    lock_flag = 1'b1;
        endcase
    end

    always_comb begin
        if (test_en && test_sel[2])
            p0_out = (test_sel[1:0] == 2'b00) ? fb_half : comp_lvl;
        else
            p0_out = p0_drive;
    end

endmodule

// File: rtl/refcmp_chk.sv
module refcmp_chk #(
    parameter int RST_DLY   = 2,
    parameter int LOCK_TOL  = 2,
    parameter int MAX_RATIO = 448
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_edge,
    input logic       comp_tick,
    input logic       fb_tick,
    input logic       pd_up,
    input logic       pd_dn,
    input logic       pd_one_sided,
    input logic       locked,
    input logic       test_en,
    input logic [2:0] test_sel,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       lock_flag
);

    logic [7:0]  both_cnt;
    logic [7:0]  os_cnt;
    logic [15:0] ref_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            both_cnt <= '0;
            os_cnt   <= '0;
            ref_cnt  <= '0;
        end else begin
            both_cnt <= (pd_up && pd_dn) ? ((both_cnt == 8'hFF) ? both_cnt : both_cnt + 8'd1) : 8'd0;
            os_cnt   <= pd_one_sided ? ((os_cnt == 8'hFF) ? os_cnt : os_cnt + 8'd1) : 8'd0;
            if (comp_tick)
                ref_cnt <= '0;
            else if (ref_edge && (ref_cnt != 16'hFFFF))
                ref_cnt <= ref_cnt + 16'd1;
        end
    end

    a_r1_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt <= 16'(MAX_RATIO))
        else $error("R1/R2: comparison period exceeds the largest ratio");

    a_r4_up_from_comp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_up) |-> $past(comp_tick))
        else $error("R4: up rose without a comparison edge");

    a_r4_dn_from_fb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_dn) |-> $past(fb_tick))
        else $error("R4: down rose without a feedback edge");

    a_r4_overlap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_up && pd_dn) |-> (both_cnt < 8'(RST_DLY)))
        else $error("R4: up/down overlap too long");

    a_r4_overlap_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_up && pd_dn && both_cnt == 8'(RST_DLY - 1)) |=> (!pd_up && !pd_dn))
        else $error("R4: overlap not released together");

    a_r5_breach_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (os_cnt >= 8'(LOCK_TOL)) |-> !locked)
        else $error("R5: lock held across a wide one-sided pulse");

    a_r6_sink: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && test_sel[1:0] == 2'b01) |-> (pump_dn && !pump_up && !lock_flag))
        else $error("R6: sink override");

    a_r6_off: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && test_sel[1:0] == 2'b11) |-> (!pump_dn && !pump_up && lock_flag))
        else $error("R6: off override");

endmodule

bind refcmp_top refcmp_chk #(
    .RST_DLY   (RST_DLY),
    .LOCK_TOL  (LOCK_TOL),
    .MAX_RATIO (refcmp_pkg::MAX_RATIO)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_edge     (ref_edge),
    .comp_tick    (comp_tick),
    .fb_tick      (fb_tick),
    .pd_up        (pd_up),
    .pd_dn        (pd_dn),
    .pd_one_sided (pd_one_sided),
    .locked       (locked),
    .test_en      (test_en),
    .test_sel     (test_sel),
    .pump_up      (pump_up),
    .pump_dn      (pump_dn),
    .lock_flag    (lock_flag)
);

// File: tb/sim_refcmp_top.sv
module sim_refcmp_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [4:0] ratio_code = 5'b00000;
    logic       test_en = 1'b0;
    logic [2:0] test_sel = 3'b000;
    logic       p0_drive = 1'b0;
    logic       pump_up, pump_dn, lock_flag, p0_out;

    always #5 clk = ~clk;

    refcmp_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .fb_in      (fb_in),
        .ratio_code (ratio_code),
        .test_en    (test_en),
        .test_sel   (test_sel),
        .p0_drive   (p0_drive),
        .pump_up    (pump_up),
        .pump_dn    (pump_dn),
        .lock_flag  (lock_flag),
        .p0_out     (p0_out)
    );

    // {code, expected ratio}
    localparam logic [13:0] VEC [12] = '{
        {5'b00000, 9'd2},   {5'b00011, 9'd16},  {5'b00111, 9'd256},
        {5'b01001, 9'd5},   {5'b01100, 9'd40},  {5'b01111, 9'd320},
        {5'b10001, 9'd6},   {5'b10010, 9'd12},  {5'b10111, 9'd384},
        {5'b11001, 9'd7},   {5'b11111, 9'd448}, {5'b11101, 9'd112}
    };

    int n = 0;
    int fb_delay = 0;
    bit fb_on = 1'b0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // ref period is 2 clocks; feedback period 4 clocks, rising at n%4==3 when delay is 0
    task automatic tick();
        int ph;
        @(negedge clk);
        n++;
        ref_in = n[0];
        ph = (n + 4 - fb_delay) % 4;
        fb_in = fb_on && (ph == 3 || ph == 0);
        #1;
    endtask

    task automatic run(input int k);
        repeat (k) tick();
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic prev;
        bit   seen;
        prev = p0_out;
        seen = 1'b0;
        while (!seen) begin
            tick();
            seen = p0_out && !prev;
            prev = p0_out;
        end
    endtask

    task automatic measure(output int len);
        logic prev;
        bit   seen;
        wait_rise();
        wait_rise();
        len  = 0;
        prev = p0_out;
        seen = 1'b0;
        while (!seen) begin
            tick();
            len++;
            seen = p0_out && !prev;
            prev = p0_out;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n  = 1'b0;
        n      = 0;
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R9 pump_up in reset", int'(pump_up), 0);
        chk("R9 pump_dn in reset", int'(pump_dn), 0);
        chk("R9 lock_flag in reset", int'(lock_flag), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic count_dir(input int k, output int uo, output int dno);
        uo  = 0;
        dno = 0;
        repeat (k) begin
            tick();
            if (pump_up && !pump_dn) uo++;
            if (pump_dn && !pump_up) dno++;
        end
    endtask

    initial begin
        int len;
        int uo;
        int dno;

        // reset state
        do_reset();
        chk("R8 p0 follows p0_drive after reset", int'(p0_out), 0);

        // ratio table: comparison clock on p0, pump off
        test_en  = 1'b1;
        test_sel = 3'b111;
        for (int i = 0; i < 12; i++) begin
            ratio_code = VEC[i][13:9];
            measure(len);
            chk((VEC[i][13:12] == 2'b00) ? "R1 divide ratio" : "R2 divide ratio",
                len, 2 * int'(VEC[i][8:0]));
        end

        // reserved codes keep 112
        ratio_code = 5'b01000; measure(len); chk("R3 reserved 01000", len, 224);
        ratio_code = 5'b10000; measure(len); chk("R3 reserved 10000", len, 224);
        ratio_code = 5'b11000; measure(len); chk("R3 reserved 11000", len, 224);

        // lock acquisition with aligned feedback, ratio 2
        test_en    = 1'b0;
        test_sel   = 3'b000;
        ratio_code = 5'b00000;
        fb_on      = 1'b1;
        fb_delay   = 0;
        do_reset();
        run(160);
        chk("R5 not locked after 40 periods", int'(lock_flag), 0);
        count_dir(40, uo, dno);
        chk("R4 aligned: no up-only cycles", uo, 0);
        chk("R4 aligned: no down-only cycles", dno, 0);
        run(200);
        chk("R5 locked after 64+ periods", int'(lock_flag), 1);

        // test overrides while locked
        test_en = 1'b1; test_sel = 3'b001; tick();
        chk("R6 sink pump_dn", int'(pump_dn), 1);
        chk("R6 sink pump_up", int'(pump_up), 0);
        chk("R6 sink lock_flag", int'(lock_flag), 0);
        test_sel = 3'b010; tick();
        chk("R6 source pump_up", int'(pump_up), 1);
        chk("R6 source pump_dn", int'(pump_dn), 0);
        chk("R6 source lock_flag", int'(lock_flag), 0);
        test_sel = 3'b000; tick();
        chk("R7 te=1 normal keeps lock", int'(lock_flag), 1);
        test_en = 1'b0; test_sel = 3'b011; tick();
        chk("R7 te=0 ignores select", int'(lock_flag), 1);
        test_sel = 3'b000;

        // feedback late by one cycle: up-only pulses, lock kept
        fb_delay = 1;
        run(320);
        count_dir(40, uo, dno);
        chk("R4 lagging fb gives up pulses", int'(uo > 0), 1);
        chk("R4 lagging fb no down-only", dno, 0);
        chk("R5 one-cycle offset keeps lock", int'(lock_flag), 1);

        // feedback early by one cycle: down-only pulses, lock kept
        fb_delay = 3;
        run(320);
        count_dir(40, uo, dno);
        chk("R4 leading fb gives down pulses", int'(dno > 0), 1);
        chk("R4 leading fb no up-only", uo, 0);
        chk("R5 one-cycle lead keeps lock", int'(lock_flag), 1);

        // two-cycle offset breaks lock
        fb_delay = 2;
        run(40);
        chk("R5 two-cycle offset drops lock", int'(lock_flag), 0);

        // missing feedback: up saturates
        fb_on = 1'b0;
        run(20);
        chk("R4 no feedback holds up", int'(pump_up), 1);
        chk("R4 no feedback no down", int'(pump_dn), 0);
        test_en = 1'b1; test_sel = 3'b011; tick();
        chk("R6 off forces lock_flag", int'(lock_flag), 1);
        chk("R6 off pump_up", int'(pump_up), 0);

        // port routing
        p0_drive = 1'b1; test_sel = 3'b001; tick();
        chk("R8 t2=0 p0 follows drive", int'(p0_out), 1);
        test_en = 1'b0; test_sel = 3'b101; p0_drive = 1'b0; tick();
        chk("R8 te=0 p0 follows drive", int'(p0_out), 0);
        fb_on = 1'b1; fb_delay = 0;
        test_en = 1'b1; test_sel = 3'b100;
        measure(len);
        chk("R8 p0 = feedback/2 period", len, 8);
        test_sel = 3'b101;
        measure(len);
        chk("R8 p0 = comparison clock period", len, 4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule